// File: doc/BRIEF.md
# USB OTG Event Interrupt Register

This block sits beside a USB On-The-Go port controller. It watches the sampled bus line state and a set of session-related indications, and it detects bus events itself. Each event latches a sticky flag in a 16-bit status word that software reads. Software acknowledges a flag by writing a 1 to its position; writing 0 leaves the flag as it is. A single interrupt request combines the flags that software has enabled.

The status word is built from three kinds of source. The first is a set of line-state detectors: an SE0 duration timer, a J-to-K resume detector that works only while the port is suspended, and a session-request detector. The session-request detector follows either VBUS pulsing or data-line pulsing, and a select input chooses which. The second kind is a timeout strobe from an external OTG timer. The third kind is seven single-cycle change strobes for session, connect, suspend and ID conditions.

The SE0 timer is a small state machine. In `T_IDLE` the line is not in SE0. On the first sampled SE0 it moves from `T_IDLE` to `T_COUNT`, where it counts consecutive SE0 samples. When the count reaches the threshold while the line is still SE0, it moves from `T_COUNT` to `T_DONE` and raises a one-cycle hit. If the line leaves SE0 during counting, it moves from `T_COUNT` back to `T_IDLE`. It then waits in `T_DONE` until the line leaves SE0, and on that exit moves from `T_DONE` back to `T_IDLE`. The threshold is 2 ms worth of clock cycles: 2 × `CLK_KHZ`.

Top module: `otg_evt_irq`

## Requirements
- R1: After reset every status bit reads 0 and `irq` is low.
- R2: Status bits 15 to 11 always read 0.
- R3: Writing with `wr_en` high clears every status bit whose `wr_data` bit is 1. Bits whose `wr_data` bit is 0 keep their value.
- R4: If an event for a bit and a write-1 clear of that bit arrive in the same cycle, the bit ends up set.
- R5: Bit 10 sets on the edge that samples `tmr_timeout` high.
- R6: `line_st` encodes 2'b00 = SE0, 2'b01 = J, 2'b10 = K and 2'b11 = SE1. Bit 9 sets on the clock edge that samples SE0 for the (2 × `CLK_KHZ` + 1)th consecutive time. After only 2 × `CLK_KHZ` consecutive SE0 samples, bit 9 is still 0.
- R7: Bit 9 sets at most once in each unbroken SE0 period, even after it has been cleared during that period. Any non-SE0 sample restarts the count from zero.
- R8: Bit 7 sets when `suspended` is high, the previous sampled line state was J and the current one is K. A J-to-K change while `suspended` is low does not set it, and neither does an SE0-to-K change.
- R9: Bit 8 sets on `vbus_pulse` when `srp_sel` is 0, and on `dline_pulse` when `srp_sel` is 1. The pulse that is not selected is ignored.
- R10: Bit i, for i from 0 to 6, sets on the edge that samples `chg_strb[i]` high. From bit 6 down, the bits mean: suspend change, remote connect change, B-session-valid change, A-session-valid change, B-session-end change, A-VBUS-valid change and ID change.
- R11: `irq` is high exactly when some status bit i (0 to 10) is 1 and `irq_en[i]` is 1. It follows the status word with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st | input | 2 | Synchronized line state (00 SE0, 01 J, 10 K, 11 SE1) |
| suspended | input | 1 | Port is in the suspend state |
| vbus_pulse | input | 1 | VBUS pulsing seen (single-cycle) |
| dline_pulse | input | 1 | Data-line pulsing seen (single-cycle) |
| srp_sel | input | 1 | Session-request source: 0 VBUS, 1 data line |
| tmr_timeout | input | 1 | OTG timer timeout strobe |
| chg_strb | input | 7 | Change strobes for status bits 6..0 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 11 | Write-1-to-clear mask for bits 10..0 |
| irq_en | input | 11 | Per-bit interrupt enable for bits 10..0 |
| stat | output | 16 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
A count in the SE0 timer that is off by one moves the first appearance of bit 9 by one cycle relative to the threshold edge. That shift is visible on the cycle right after that edge. A timer that does not restart, or that leaves its done state too early, shows a second or early bit 9 within one threshold period of the disturbance. A wrong previous-line register shows as bit 7 being set, or failing to set, one edge after the K sample. Errors in set, clear or enable priority show on `stat` and `irq` one edge after the write or strobe.

// File: rtl/otg_evt_pkg.sv
package otg_evt_pkg;
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    localparam int STAT_W = 16;
    localparam int EVT_W  = 11;
    localparam int CHG_W  = 7;
    localparam int B_TMR  = 10;
    localparam int B_SE0  = 9;
    localparam int B_SRP  = 8;
    localparam int B_RSM  = 7;
endpackage

// File: rtl/otg_se0_timer.sv
module otg_se0_timer
    import otg_evt_pkg::*;
#(
    parameter int LIMIT = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line,
    output logic       hit
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef enum logic [1:0] {T_IDLE, T_COUNT, T_DONE} tstate_t;

    tstate_t       state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          in_se0;

    assign in_se0 = (line == LS_SE0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        hit     = 1'b0;
        unique case (state)
            T_IDLE: begin
                if (in_se0) begin
                    nxt     = T_COUNT;
                    cnt_nxt = CW'(1);
                end
            end
            T_COUNT: begin
                if (!in_se0) begin
                    nxt     = T_IDLE;
                    cnt_nxt = '0;
                end else if (cnt == CW'(LIMIT)) begin
                    nxt     = T_DONE;
                    cnt_nxt = '0;
                    hit     = 1'b1;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            T_DONE: begin
                if (!in_se0) nxt = T_IDLE;
            end
            default: nxt = T_IDLE;
        endcase
    end

    // R7
    se0_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R6
    se0_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(line) == LS_SE0);
endmodule

// File: rtl/otg_resume_det.sv
module otg_resume_det
    import otg_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line,
    input  logic       susp,
    output logic       j2k
);
    logic [1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= LS_SE0;
        else        prev <= line;
    end

    assign j2k = susp && (prev == LS_J) && (line == LS_K);

    // R8
    resume_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        j2k |-> $past(line) == LS_J);
endmodule

// File: rtl/otg_evt_irq.sv
module otg_evt_irq
    import otg_evt_pkg::*;
#(
    parameter int CLK_KHZ = 250000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          line_st,
    input  logic                suspended,
    input  logic                vbus_pulse,
    input  logic                dline_pulse,
    input  logic                srp_sel,
    input  logic                tmr_timeout,
    input  logic [CHG_W-1:0]    chg_strb,
    input  logic                wr_en,
    input  logic [EVT_W-1:0]    wr_data,
    input  logic [EVT_W-1:0]    irq_en,
    output logic [STAT_W-1:0]   stat,
    output logic                irq
);
    localparam int SE0_CYCLES = 2 * CLK_KHZ;
    localparam int RSV_W      = STAT_W - EVT_W;

    logic             se0_hit, j2k, srp_evt;
    logic [EVT_W-1:0] evt, stat_q;

    otg_se0_timer #(.LIMIT(SE0_CYCLES)) u_se0 (
        .clk  (clk),
        .rst_n(rst_n),
        .line (line_st),
        .hit  (se0_hit)
    );

    otg_resume_det u_rsm (
        .clk  (clk),
        .rst_n(rst_n),
        .line (line_st),
        .susp (suspended),
        .j2k  (j2k)
    );

    assign srp_evt = srp_sel ? dline_pulse : vbus_pulse;

    always_comb begin
        evt               = '0;
        evt[CHG_W-1:0]    = chg_strb;
        evt[B_RSM]        = j2k;
        evt[B_SRP]        = srp_evt;
        evt[B_SE0]        = se0_hit;
        evt[B_TMR]        = tmr_timeout;
    end

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     stat_q[i] <= 1'b0;
            else if (evt[i])                stat_q[i] <= 1'b1;
            else if (wr_en && wr_data[i])   stat_q[i] <= 1'b0;
        end

        // R4
        set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> stat_q[i]);

        // R3
        clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[i] && !evt[i]) |=> !stat_q[i]);

        // R3
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && !(wr_en && wr_data[i])) |=> stat_q[i] == $past(stat_q[i]));
    end

    assign stat = {{RSV_W{1'b0}}, stat_q};
    assign irq  = |(stat_q & irq_en);
endmodule

// File: tb/tb_otg_evt_irq.sv
module tb_otg_evt_irq;
    localparam int KHZ = 8;
    localparam int LIM = 2 * KHZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  line_st = 2'b01;
    logic        suspended = 1'b0;
    logic        vbus_pulse = 1'b0;
    logic        dline_pulse = 1'b0;
    logic        srp_sel = 1'b0;
    logic        tmr_timeout = 1'b0;
    logic [6:0]  chg_strb = '0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_data = '0;
    logic [10:0] irq_en = '0;
    logic [15:0] stat;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    otg_evt_irq #(.CLK_KHZ(KHZ)) dut (
        .clk(clk), .rst_n(rst_n), .line_st(line_st), .suspended(suspended),
        .vbus_pulse(vbus_pulse), .dline_pulse(dline_pulse), .srp_sel(srp_sel),
        .tmr_timeout(tmr_timeout), .chg_strb(chg_strb), .wr_en(wr_en),
        .wr_data(wr_data), .irq_en(irq_en), .stat(stat), .irq(irq)
    );

    typedef struct packed {
        logic        tmr;
        logic        vb;
        logic        dp;
        logic        sel;
        logic [6:0]  chg;
        logic        wr;
        logic [10:0] wd;
        logic [10:0] en;
        logic [15:0] exp_stat;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,7'h55,1'b0,11'h000,11'h000,16'h0055,1'b0}, // R10
        '{1'b0,1'b0,1'b0,1'b0,7'h2A,1'b0,11'h000,11'h040,16'h007F,1'b1}, // R10 R11
        '{1'b1,1'b0,1'b0,1'b0,7'h00,1'b0,11'h000,11'h000,16'h047F,1'b0}, // R5
        '{1'b0,1'b1,1'b0,1'b0,7'h00,1'b0,11'h000,11'h100,16'h057F,1'b1}, // R9
        '{1'b0,1'b0,1'b0,1'b0,7'h00,1'b1,11'h100,11'h100,16'h047F,1'b0}, // R3
        '{1'b0,1'b0,1'b1,1'b0,7'h00,1'b0,11'h000,11'h000,16'h047F,1'b0}, // R9
        '{1'b0,1'b0,1'b1,1'b1,7'h00,1'b0,11'h000,11'h000,16'h057F,1'b0}, // R9
        '{1'b0,1'b1,1'b0,1'b1,7'h00,1'b1,11'h100,11'h000,16'h047F,1'b0}, // R9 R3
        '{1'b1,1'b0,1'b0,1'b0,7'h00,1'b1,11'h7FF,11'h400,16'h0400,1'b1}, // R4
        '{1'b0,1'b0,1'b0,1'b0,7'h00,1'b1,11'h000,11'h400,16'h0400,1'b1}, // R3
        '{1'b0,1'b0,1'b0,1'b0,7'h00,1'b1,11'h400,11'h7FF,16'h0000,1'b0}  // R3 R11
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr_strobes();
        tmr_timeout = 1'b0; vbus_pulse = 1'b0; dline_pulse = 1'b0;
        chg_strb = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        irq_en = '1;
        repeat (3) @(negedge clk);
        chk("R1 stat in reset", stat, 16'h0000);
        chk("R1 irq in reset", {15'b0, irq}, 16'h0000);
        rst_n = 1'b1;
        tick();
        chk("R1 stat after reset", stat, 16'h0000);
        chk("R1 irq after reset", {15'b0, irq}, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            tmr_timeout = VECS[v].tmr;
            vbus_pulse  = VECS[v].vb;
            dline_pulse = VECS[v].dp;
            srp_sel     = VECS[v].sel;
            chg_strb    = VECS[v].chg;
            wr_en       = VECS[v].wr;
            wr_data     = VECS[v].wd;
            irq_en      = VECS[v].en;
            tick();
            chk($sformatf("vector %0d stat R3 R4 R5 R9 R10", v), stat, VECS[v].exp_stat);
            chk($sformatf("vector %0d irq R11", v), {15'b0, irq}, {15'b0, VECS[v].exp_irq});
            clr_strobes();
        end

        // R2: everything set, reserved field stays zero; R11 single enable
        chg_strb = 7'h7F; tmr_timeout = 1'b1; srp_sel = 1'b0; vbus_pulse = 1'b1;
        irq_en = 11'h001;
        tick();
        clr_strobes();
        chk("R2 reserved bits", {11'b0, stat[15:11]}, 16'h0000);
        chk("R10 R5 R9 all set", stat, 16'h057F);
        chk("R11 irq from bit0", {15'b0, irq}, 16'h0001);
        wr_en = 1'b1; wr_data = 11'h7FF;
        tick();
        clr_strobes();
        chk("R3 clear all", stat, 16'h0000);
        chk("R11 irq low", {15'b0, irq}, 16'h0000);

        // R6: threshold edge
        line_st = 2'b00;
        repeat (LIM) tick();
        chk("R6 not yet at threshold", {15'b0, stat[9]}, 16'h0000);
        tick();
        chk("R6 set one past threshold", {15'b0, stat[9]}, 16'h0001);

        // R7: clear inside same SE0 period, no second set
        wr_en = 1'b1; wr_data = 11'h200;
        tick();
        clr_strobes();
        chk("R7 cleared", {15'b0, stat[9]}, 16'h0000);
        repeat (3 * LIM) tick();
        chk("R7 once per SE0 period", {15'b0, stat[9]}, 16'h0000);

        // R7: a break restarts the count
        line_st = 2'b01; tick();
        line_st = 2'b00; repeat (LIM) tick();
        line_st = 2'b01; tick();
        line_st = 2'b00; repeat (LIM) tick();
        chk("R7 restart after break", {15'b0, stat[9]}, 16'h0000);
        line_st = 2'b01; tick();
        chk("R7 still clear after exit", {15'b0, stat[9]}, 16'h0000);

        // R8: resume detection
        suspended = 1'b0;
        line_st = 2'b01; tick();
        line_st = 2'b10; tick();
        chk("R8 J to K not suspended", {15'b0, stat[7]}, 16'h0000);
        line_st = 2'b01; tick();
        suspended = 1'b1;
        line_st = 2'b10; tick();
        chk("R8 J to K suspended", {15'b0, stat[7]}, 16'h0001);
        wr_en = 1'b1; wr_data = 11'h080;
        line_st = 2'b00; tick();
        clr_strobes();
        line_st = 2'b10; tick();
        chk("R8 SE0 to K ignored", {15'b0, stat[7]}, 16'h0000);
        line_st = 2'b01; tick();
        suspended = 1'b0;
        chk("R2 R3 final word", stat, 16'h0000);

        finish_run();
    end
endmodule